// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller

This block scans a passive segment LCD of up to 44 segment pins by 5 common pins. A CPU fills a small display memory over a byte-wide write bus and programs a one-time option byte that sets the bias (two or three drive levels), the duty (2 to 5 active commons) and whether scanning runs at all. A low-frequency tick from the chip's timebase paces the scan. The block selects one common per line in order and presents the stored segment bits for that common on the segment pins. It gives every pin a 2-bit drive-level code, which an external resistor or capacitor ladder turns into panel voltages.

Before the option byte is first written, the panel shows every dot lit. This power-on view uses five commons at the three-level bias. The drive polarity flips after each full frame, so no pin carries a net DC level. A display-memory write reaches the pins only at the next line boundary, so no line is ever shown half old and half new. Segment pins chosen by the static mask parameter are handed to general-purpose I/O and never carry LCD drive.

The control FSM has three states. ST_ALLON is the power-on all-lit scan. ST_SCAN is normal scanning with the programmed option. ST_OFF means the option was written with scanning disabled. Only two transitions exist, and both are taken on the first option write while in ST_ALLON. T_CFG_RUN goes to ST_SCAN when the run bit is 1. T_CFG_STOP goes to ST_OFF when the run bit is 0. ST_SCAN and ST_OFF are terminal until reset.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset the block is in the all-lit state. Five commons are scanned at three-level bias, one tick per line, starting at common 0 with polarity 0. Every unmasked segment is driven as "on", whatever the display memory holds.
- R2: Only the first write to the option address is accepted. Every later option write is ignored until reset.
- R3: Option byte encoding, at address 2^ADDR_W-1: bit 0 is bias (1 = three-level 1/3, 0 = two-level 1/2). Bits 2:1 set the active common count minus 2 (0 to 3 gives 2 to 5 commons). Bit 3 is run (1 = scan). The write restarts the scan at common 0, polarity 0, with row 0 loaded.
- R4: Active commons are selected one per line in ascending order, exactly one at a time. Commons above the active count always sit at the non-select level.
- R5: A line lasts two ticks when two commons are active and one tick otherwise.
- R6: Polarity toggles when the scan wraps from the last active common back to common 0.
- R7: Level codes are 0 = V0 through 3 = V3. At three-level bias, a selected common is V3 (polarity 0) or V0 (polarity 1), and a non-selected common is V1 or V2. An "on" segment is V0 or V3, and an "off" segment is V2 or V1.
- R8: At two-level bias, the mid level is code 1. Non-selected commons sit at code 1. An "off" segment is V3 (polarity 0) or V0 (polarity 1). Selected commons and "on" segments follow R7. Code 2 never appears.
- R9: A display write to byte address r*ceil(NUM_SEG/8)+b sets segments b*8+i of common row r from data bit i. Writes to rows at or above NUM_COM, and to bits past the last segment, change nothing.
- R10: The segment data shown for a line is latched at the line boundary. A display write does not alter the pins before the next boundary.
- R11: A segment whose SEG_IO_MASK bit is 1 always outputs code 0 with its drive-enable low. All other segments have drive-enable high.
- R12: In the stopped state every common and segment outputs code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle scan pace pulse (256 Hz base) |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte address: display rows, or option at top address |
| wr_data | input | 8 | Write data byte |
| com_lvl | output | 2*NUM_COM | Drive-level code per common, common c at [2c+1:2c] |
| seg_lvl | output | 2*NUM_SEG | Drive-level code per segment, segment k at [2k+1:2k] |
| seg_drv_en | output | NUM_SEG | High where a segment pin carries LCD drive |

## Verification
The bench builds the block with 12 segments, 5 commons, a 4-bit address and a mask that gives segments 0 and 11 to I/O. These settings make two bytes per row and put the option byte at address 15. Every pin can then be compared against an arithmetic model after every tick. Separate reset phases cover the power-on view, each duty from 2 to 5, both biases and the stopped state. Each sweep runs through several full frames, so every common position meets both polarities. The same small layout puts out-of-range row addresses, unused high bits of a row, mid-line and mid-two-tick writes and late option writes within a few cycles.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        ST_ALLON = 2'd0,
        ST_SCAN  = 2'd1,
        ST_OFF   = 2'd2
    } lcd_state_t;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LV0 = 2'd0;
    localparam lvl_t LV1 = 2'd1;
    localparam lvl_t LV2 = 2'd2;
    localparam lvl_t LV3 = 2'd3;

    // Common pin level for one line.
    function automatic lvl_t com_level(input logic sel, input logic pol, input logic third);
        if (sel)
            return pol ? LV0 : LV3;
        else if (third)
            return pol ? LV2 : LV1;
        else
            return LV1;
    endfunction

    // Segment pin level for one line.
    function automatic lvl_t seg_level(input logic on, input logic pol, input logic third);
        if (on)
            return pol ? LV3 : LV0;
        else if (third)
            return pol ? LV1 : LV2;
        else
            return pol ? LV0 : LV3;
    endfunction

endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int NUM_SEG = 44,
    parameter int NUM_COM = 5,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NUM_SEG-1:0] rows [NUM_COM]
);

    localparam int BYTES_PER_ROW = (NUM_SEG + 7) / 8;

    for (genvar r = 0; r < NUM_COM; r++) begin : g_row
        for (genvar k = 0; k < NUM_SEG; k++) begin : g_bit
            localparam int BYTE_ADDR = r * BYTES_PER_ROW + k / 8;
            localparam int BIT_POS   = k % 8;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    rows[r][k] <= 1'b0;
                else if (wr_en && wr_addr == ADDR_W'(BYTE_ADDR))
                    rows[r][k] <= wr_data[BIT_POS];
            end
        end
    end

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 44,
    parameter int NUM_COM = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      opt_wr,
    input  logic [3:0]                opt_bits,
    input  logic [NUM_SEG-1:0]        rows [NUM_COM],
    output lcd_state_t                st,
    output logic [$clog2(NUM_COM)-1:0] com_idx,
    output logic                      pol,
    output logic                      bias_third,
    output logic [NUM_SEG-1:0]        line_bits
);

    localparam int CW = $clog2(NUM_COM);

    lcd_state_t     st_q, st_d;
    logic [1:0]     duty_q;
    logic           sub_q;
    logic [CW-1:0]  com_q;
    logic [CW-1:0]  last_com;
    logic [CW-1:0]  nxt_com;
    logic           wrap;
    logic           line_end;
    logic           cfg_take;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_ALLON;
        else
            st_q <= st_d;
    end

    // Transitions: T_CFG_RUN and T_CFG_STOP, both only from ST_ALLON.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ALLON: if (opt_wr) st_d = opt_bits[3] ? ST_SCAN : ST_OFF;
            ST_SCAN:  st_d = ST_SCAN;
            ST_OFF:   st_d = ST_OFF;
            default:  st_d = ST_ALLON;
        endcase
    end

    assign cfg_take = opt_wr && (st_q == ST_ALLON);
    assign last_com = CW'(duty_q) + CW'(1);
    assign wrap     = (com_q == last_com);
    assign nxt_com  = wrap ? '0 : com_q + CW'(1);
    // Two-common duty holds each line for two ticks.
    assign line_end = (duty_q != 2'd0) || sub_q;

    // Line and frame counters; reset values form the power-on view.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q     <= 2'd3;
            bias_third <= 1'b1;
            com_q      <= '0;
            pol        <= 1'b0;
            sub_q      <= 1'b0;
            line_bits  <= '0;
        end else if (cfg_take) begin
            duty_q     <= opt_bits[2:1];
            bias_third <= opt_bits[0];
            com_q      <= '0;
            pol        <= 1'b0;
            sub_q      <= 1'b0;
            line_bits  <= rows[0];
        end else if (tick) begin
            if (line_end) begin
                sub_q     <= 1'b0;
                com_q     <= nxt_com;
                line_bits <= rows[nxt_com];
                if (wrap)
                    pol <= ~pol;
            end else begin
                sub_q <= 1'b1;
            end
        end
    end

    assign st      = st_q;
    assign com_idx = com_q;

endmodule

// File: rtl/lcd_drive_enc.sv
module lcd_drive_enc
    import lcd_scan_pkg::*;
#(
    parameter int                 NUM_SEG     = 44,
    parameter int                 NUM_COM     = 5,
    parameter logic [NUM_SEG-1:0] SEG_IO_MASK = '0
) (
    input  lcd_state_t                 st,
    input  logic [$clog2(NUM_COM)-1:0] com_idx,
    input  logic                       pol,
    input  logic                       bias_third,
    input  logic [NUM_SEG-1:0]         line_bits,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl,
    output logic [NUM_SEG-1:0]         seg_drv_en
);

    localparam int CW = $clog2(NUM_COM);

    logic stopped;
    logic all_lit;

    assign stopped = (st == ST_OFF);
    assign all_lit = (st == ST_ALLON);

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_lvl[2*c +: 2] = stopped ? LV0
                                 : com_level(com_idx == CW'(c), pol, bias_third);
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        if (SEG_IO_MASK[k]) begin : g_io
            assign seg_lvl[2*k +: 2] = LV0;
            assign seg_drv_en[k]     = 1'b0;
        end else begin : g_lcd
            assign seg_lvl[2*k +: 2] = stopped ? LV0
                                     : seg_level(all_lit || line_bits[k], pol, bias_third);
            assign seg_drv_en[k]     = 1'b1;
        end
    end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int                 NUM_SEG     = 44,
    parameter int                 NUM_COM     = 5,
    parameter int                 ADDR_W      = 5,
    parameter logic [NUM_SEG-1:0] SEG_IO_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl,
    output logic [NUM_SEG-1:0]   seg_drv_en
);

    localparam int CW       = $clog2(NUM_COM);
    localparam int OPT_ADDR = (1 << ADDR_W) - 1;

    logic [NUM_SEG-1:0] rows [NUM_COM];
    lcd_state_t         st;
    logic [CW-1:0]      com_idx;
    logic               pol;
    logic               bias_third;
    logic [NUM_SEG-1:0] line_bits;
    logic               opt_wr;

    assign opt_wr = wr_en && (wr_addr == ADDR_W'(OPT_ADDR));

    lcd_disp_ram #(
        .NUM_SEG (NUM_SEG),
        .NUM_COM (NUM_COM),
        .ADDR_W  (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rows    (rows)
    );

    lcd_line_seq #(
        .NUM_SEG (NUM_SEG),
        .NUM_COM (NUM_COM)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .opt_wr     (opt_wr),
        .opt_bits   (wr_data[3:0]),
        .rows       (rows),
        .st         (st),
        .com_idx    (com_idx),
        .pol        (pol),
        .bias_third (bias_third),
        .line_bits  (line_bits)
    );

    lcd_drive_enc #(
        .NUM_SEG     (NUM_SEG),
        .NUM_COM     (NUM_COM),
        .SEG_IO_MASK (SEG_IO_MASK)
    ) u_enc (
        .st         (st),
        .com_idx    (com_idx),
        .pol        (pol),
        .bias_third (bias_third),
        .line_bits  (line_bits),
        .com_lvl    (com_lvl),
        .seg_lvl    (seg_lvl),
        .seg_drv_en (seg_drv_en)
    );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
    import lcd_scan_pkg::*;
#(
    parameter int                 NUM_SEG     = 44,
    parameter int                 NUM_COM     = 5,
    parameter logic [NUM_SEG-1:0] SEG_IO_MASK = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 wr_en,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [NUM_SEG-1:0]   seg_drv_en,
    input lcd_state_t           st,
    input logic                 bias_third
);

    logic [NUM_COM-1:0] com_extreme;
    logic               any_code2;

    always_comb begin
        any_code2 = 1'b0;
        for (int c = 0; c < NUM_COM; c++) begin
            com_extreme[c] = (com_lvl[2*c +: 2] == LV0) || (com_lvl[2*c +: 2] == LV3);
            if (com_lvl[2*c +: 2] == LV2) any_code2 = 1'b1;
        end
        for (int k = 0; k < NUM_SEG; k++)
            if (seg_lvl[2*k +: 2] == LV2) any_code2 = 1'b1;
    end

    // R4
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF) |-> ($countones(com_extreme) == 1));

    // R8
    half_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && !bias_third) |-> !any_code2);

    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (com_lvl == '0 && seg_lvl == '0));

    // R10
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(com_lvl) && $stable(seg_lvl)));

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_ALLON) |=> ($stable(st) && $stable(bias_third)));

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_mask
        if (SEG_IO_MASK[k]) begin : g_io
            // R11
            io_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (seg_lvl[2*k +: 2] == LV0) && !seg_drv_en[k]);
        end
    end

endmodule

bind lcd_scan_ctrl lcd_scan_chk #(
    .NUM_SEG     (NUM_SEG),
    .NUM_COM     (NUM_COM),
    .SEG_IO_MASK (SEG_IO_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl),
    .seg_drv_en (seg_drv_en),
    .st         (st),
    .bias_third (bias_third)
);

// File: tb/lcd_scan_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_bench;

    localparam int NS  = 12;
    localparam int NC  = 5;
    localparam int AW  = 4;
    localparam int BPR = 2;
    localparam int OPT = 15;
    localparam logic [NS-1:0] MASK = 12'h801;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;
    logic [NS-1:0]   seg_drv_en;

    always #5 clk = ~clk;

    lcd_scan_ctrl #(
        .NUM_SEG (NS), .NUM_COM (NC), .ADDR_W (AW), .SEG_IO_MASK (MASK)
    ) u_lcd_scan_ctrl (
        .clk (clk), .rst_n (rst_n), .tick (tick), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data),
        .com_lvl (com_lvl), .seg_lvl (seg_lvl), .seg_drv_en (seg_drv_en)
    );

    int nchk = 0;
    int nfail = 0;

    // Reference model state.
    int        n, duty, tpl;
    bit        third, allon, off, locked;
    logic [NS-1:0] mram [NC];
    logic [NS-1:0] disp;

    function automatic logic [1:0] ecom(bit sel, bit pol, bit th);
        if (sel) return pol ? 2'd0 : 2'd3;
        if (th)  return pol ? 2'd2 : 2'd1;
        return 2'd1;
    endfunction

    function automatic logic [1:0] eseg(bit on, bit pol, bit th);
        if (on) return pol ? 2'd3 : 2'd0;
        if (th) return pol ? 2'd1 : 2'd2;
        return pol ? 2'd0 : 2'd3;
    endfunction

    task automatic check_all(input string req);
        logic [2*NC-1:0] ec;
        logic [2*NS-1:0] es;
        logic [NS-1:0]   ed;
        int line, c;
        bit pol;
        line = n / tpl;
        c    = line % duty;
        pol  = ((line / duty) % 2) == 1;
        for (int i = 0; i < NC; i++)
            ec[2*i +: 2] = off ? 2'd0 : ecom(i == c, pol, third);
        for (int k = 0; k < NS; k++) begin
            // R11: masked pins carry code 0 and no drive enable.
            ed[k] = !MASK[k];
            es[2*k +: 2] = (off || MASK[k]) ? 2'd0 : eseg(allon || disp[k], pol, third);
        end
        nchk++;
        if (com_lvl !== ec || seg_lvl !== es || seg_drv_en !== ed) begin
            nfail++;
            $display("FAIL %s n=%0d com=%h exp %h seg=%h exp %h en=%h exp %h",
                     req, n, com_lvl, ec, seg_lvl, es, seg_drv_en, ed);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0; duty = 5; tpl = 1; third = 1; allon = 1; off = 0; locked = 0;
        for (int r = 0; r < NC; r++) mram[r] = '0;
        disp = '0;
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        n++;
        if (n % tpl == 0) disp = mram[(n / tpl) % duty];
        @(negedge clk);
    endtask

    task automatic do_write(input int addr, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr == OPT) begin
            if (!locked) begin
                locked = 1; allon = 0;
                third = d[0];
                duty  = int'(d[2:1]) + 2;
                tpl   = (duty == 2) ? 2 : 1;
                off   = !d[3];
                n     = 0;
                disp  = mram[0];
            end
        end else if (addr < NC * BPR) begin
            for (int i = 0; i < 8; i++)
                if ((addr % BPR) * 8 + i < NS) mram[addr / BPR][(addr % BPR) * 8 + i] = d[i];
        end
        @(negedge clk);
    endtask

    task automatic fill_rows(input int seed);
        for (int a = 0; a < NC * BPR; a++)
            do_write(a, 8'(8'hA5 ^ (a * 37 + seed * 11)));
    endtask

    task automatic sweep(input int cnt, input string req);
        for (int t = 0; t < cnt; t++) begin
            do_tick();
            check_all(req);
        end
    endtask

    initial begin
        #1_500_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // Phase 1: power-on view, then 1/3 bias with four commons.
        do_reset();
        check_all("R1 reset all-on");
        fill_rows(1);
        check_all("R1 memory ignored while all-on");
        sweep(12, "R1/R6/R7 all-on scan");
        do_write(OPT, 8'h0D);
        check_all("R3 option applied");
        sweep(16, "R4/R5/R6/R7 four commons");
        do_write(((n / tpl + 0) % duty) * BPR, 8'h3C);
        check_all("R10 write held until boundary");
        sweep(9, "R10 new row after boundary");
        do_write(OPT, 8'h02);
        sweep(8, "R2 late option ignored");
        do_write(12, 8'hFF);
        do_write(1, 8'hFF);
        sweep(8, "R9 out of range and high bits");

        // Phase 2: 1/2 bias, two commons, two ticks per line.
        do_reset();
        fill_rows(2);
        do_write(OPT, 8'h08);
        check_all("R3 half bias two commons");
        sweep(9, "R5/R8 two-tick lines");
        do_write(((n / tpl) % duty) * BPR + 1, 8'h0F);
        check_all("R10 mid-line write held");
        sweep(9, "R5/R8/R10 after mid-line write");

        // Phase 3: 1/3 bias, three commons.
        do_reset();
        fill_rows(3);
        do_write(OPT, 8'h0B);
        sweep(12, "R4/R6 three commons");

        // Phase 4: 1/2 bias, five commons.
        do_reset();
        fill_rows(4);
        do_write(OPT, 8'h0E);
        sweep(12, "R8/R9 five commons half bias");

        // Phase 5: stopped.
        do_reset();
        fill_rows(5);
        do_write(OPT, 8'h07);
        check_all("R12 stopped");
        sweep(4, "R12 stopped with ticks");
        do_write(OPT, 8'h0F);
        sweep(3, "R2 stopped stays stopped");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule